// File: doc/BRIEF.md
# Checkpointed Poison-Tracking Register File

This block is the architectural register file of an in-order core that keeps issuing past data-cache misses. It holds a working ("tail") copy of every register next to a checkpoint copy and a rally scratch copy. Each tail register also carries a poison flag, meaning its value waits on an outstanding miss, and a sequence tag that names the speculative write that last touched it.

A load that misses while the file is in normal mode makes the file copy all tail values into the checkpoint and switch to advance mode. In advance mode, writes whose sources are poisoned only mark their destination poisoned. Clean writes store their value and clear the poison. Every write is stamped with its distance from the checkpoint. When the miss returns, the core starts a rally. Deferred instructions then write back through a second port. Such a write reaches the tail copy only if the tag held there still names it, so a younger result is never overwritten. Otherwise the value is parked in the scratch copy. A rally ends either by release, which keeps the tail state, or by abort, which restores the checkpoint. Advance writes keep flowing through the tail port during a rally.

Top module: `cprf_top`

## Requirements
- R1: After reset the mode output is 0 (normal), the sequence output is 0, the fallback output is 0, and every register reads value 0 and not poisoned.
- R2: A write with the miss flag set in normal mode copies all tail values as they were before that write into the checkpoint. It poisons the destination, moves the mode to 1 (advance) and sets the sequence output to 1.
- R3: In advance or rally mode, a tail write with the poisoned-source flag or the miss flag set marks the destination poisoned and leaves its value unchanged.
- R4: In advance or rally mode, a clean tail write stores its value and clears the destination's poison flag.
- R5: Each accepted tail write in advance or rally mode raises the sequence output by one and stamps the destination's tag with the new count.
- R6: In rally mode (2), a rally write whose sequence number equals the destination's tag updates that tail register's value and poison. A rally write with a different number leaves the tail register untouched and stores its value in the scratch copy, readable on the scratch port.
- R7: When a tail write and a rally write hit the same register in one cycle, the tail write is applied and the rally value goes to the scratch copy.
- R8: An abort during rally mode reloads every tail value from the checkpoint and clears all poison. It discards the tail write of that cycle and returns to mode 0 with sequence 0 and fallback 0.
- R9: A release during rally mode returns to mode 0 with sequence 0 and keeps the tail values and poison flags as they stand.
- R10: The sequence counter saturates at its maximum (63 by default). A further tail write raises the fallback output, which stays high until the rally ends. While it is high, rally writes never update tail registers and go only to the scratch copy.
- R11: Rally start, release and abort have no effect in normal mode, and rally writes are ignored outside rally mode. Neither tail nor scratch contents change.
- R12: A tail write without the miss flag in normal mode stores its value, leaves the register not poisoned and keeps the mode at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Tail write strobe |
| wr_idx | input | IW | Tail write destination |
| wr_data | input | DW | Tail write value |
| wr_src_poison | input | 1 | A source of the writing instruction is poisoned |
| wr_miss | input | 1 | The writing instruction is a load that missed |
| rl_en | input | 1 | Rally write strobe |
| rl_idx | input | IW | Rally write destination |
| rl_data | input | DW | Rally write value |
| rl_seq | input | SEQW | Sequence number of the deferred instruction |
| rl_poison | input | 1 | Rally result is still poisoned |
| rally_start | input | 1 | Miss returned, enter rally |
| rally_done | input | 1 | Last deferred instruction completed, release checkpoint |
| rally_abort | input | 1 | Mispredict or exception in rally, restore checkpoint |
| rd_idx | input | NRD*IW | Read port indices, port k in bits k*IW upward |
| rd_data | output | NRD*DW | Tail values for the read ports |
| rd_poison | output | NRD | Poison flags for the read ports |
| sc_idx | input | IW | Scratch read index |
| sc_data | output | DW | Scratch copy value |
| mode_o | output | 2 | 0 normal, 1 advance, 2 rally |
| seq_o | output | SEQW | Current sequence count |
| runahead_o | output | 1 | Sequence overflow, fall back to plain runahead |

## Verification
The hard case is a cycle in which the tail port and the rally port name the same register. The tail port carries a clean advance result while the rally port carries a deferred result whose sequence number matches the register's current tag. Without a defined priority, the tag match would let the rally value through. The bench provokes exactly this and then reads the register on a read port, expecting the advance value. It reads the same index on the scratch port, expecting the deferred value, and checks that the sequence count still advanced. A second overlap, an abort issued together with a tail write, is judged by reading back the checkpointed values afterwards.

// File: rtl/cprf_pkg.sv
package cprf_pkg;
    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'd0,
        MODE_ADVANCE = 2'd1,
        MODE_RALLY   = 2'd2
    } cprf_mode_e;
endpackage

// File: rtl/cprf_ctrl.sv
module cprf_ctrl
    import cprf_pkg::*;
#(
    parameter int SEQW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            wr_src_poison,
    input  logic            wr_miss,
    input  logic            rally_start,
    input  logic            rally_done,
    input  logic            rally_abort,
    output cprf_mode_e      mode_o,
    output logic [SEQW-1:0] seq_o,
    output logic            runahead_o,
    output logic            take_ckpt_o,
    output logic            restore_o,
    output logic            tail_we_o,
    output logic            tail_poison_o,
    output logic [SEQW-1:0] tail_tag_o,
    output logic            rl_ok_o,
    output logic            rl_tag_en_o
);
    localparam logic [SEQW-1:0] SEQ_MAX = '1;
    localparam logic [SEQW-1:0] SEQ_ONE = SEQW'(1);

    typedef struct packed {
        cprf_mode_e      mode;
        logic [SEQW-1:0] seq;
        logic            ra;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        take_ckpt_o   = 1'b0;
        restore_o     = 1'b0;
        tail_we_o     = 1'b0;
        tail_poison_o = 1'b0;
        tail_tag_o    = '0;
        case (st_q.mode)
            MODE_NORMAL: begin
                if (wr_en) begin
                    tail_we_o = 1'b1;
                    if (wr_miss) begin
                        take_ckpt_o   = 1'b1;
                        tail_poison_o = 1'b1;
                        tail_tag_o    = SEQ_ONE;
                        st_d.mode     = MODE_ADVANCE;
                        st_d.seq      = SEQ_ONE;
                        st_d.ra       = 1'b0;
                    end
                end
            end
            default: begin
                if (st_q.mode == MODE_RALLY && rally_abort) begin
                    restore_o = 1'b1;
                    st_d.mode = MODE_NORMAL;
                    st_d.seq  = '0;
                    st_d.ra   = 1'b0;
                end else begin
                    if (wr_en) begin
                        tail_we_o     = 1'b1;
                        tail_poison_o = wr_miss | wr_src_poison;
                        if (st_q.seq == SEQ_MAX) begin
                            st_d.ra    = 1'b1;
                            tail_tag_o = SEQ_MAX;
                        end else begin
                            st_d.seq   = st_q.seq + SEQ_ONE;
                            tail_tag_o = st_q.seq + SEQ_ONE;
                        end
                    end
                    if (st_q.mode == MODE_ADVANCE && rally_start) begin
                        st_d.mode = MODE_RALLY;
                    end
                    if (st_q.mode == MODE_RALLY && rally_done) begin
                        st_d.mode = MODE_NORMAL;
                        st_d.seq  = '0;
                        st_d.ra   = 1'b0;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_NORMAL, seq: '0, ra: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o      = st_q.mode;
    assign seq_o       = st_q.seq;
    assign runahead_o  = st_q.ra;
    assign rl_ok_o     = (st_q.mode == MODE_RALLY) && !rally_abort;
    assign rl_tag_en_o = !st_q.ra;
endmodule

// File: rtl/cprf_slot.sv
module cprf_slot #(
    parameter int DW   = 32,
    parameter int SEQW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take_ckpt,
    input  logic            restore,
    input  logic            tw_sel,
    input  logic [DW-1:0]   tw_data,
    input  logic            tw_poison,
    input  logic [SEQW-1:0] tw_tag,
    input  logic            rl_sel,
    input  logic            rl_ok,
    input  logic            rl_tag_en,
    input  logic [DW-1:0]   rl_data,
    input  logic [SEQW-1:0] rl_seq,
    input  logic            rl_poison,
    output logic [DW-1:0]   val_o,
    output logic            poison_o,
    output logic [DW-1:0]   scratch_o
);
    typedef struct packed {
        logic [DW-1:0]   val;
        logic            poison;
        logic [SEQW-1:0] tag;
        logic [DW-1:0]   ckpt;
        logic [DW-1:0]   scratch;
    } slot_t;

    slot_t s_d, s_q;
    logic  rl_take;

    always_comb begin
        s_d     = s_q;
        rl_take = rl_sel && rl_ok && rl_tag_en && !tw_sel && (s_q.tag == rl_seq);
        if (restore) begin
            s_d.val    = s_q.ckpt;
            s_d.poison = 1'b0;
            s_d.tag    = '0;
        end else begin
            if (take_ckpt) begin
                s_d.ckpt = s_q.val;
            end
            if (tw_sel) begin
                s_d.tag = tw_tag;
                if (tw_poison) begin
                    s_d.poison = 1'b1;
                end else begin
                    s_d.val    = tw_data;
                    s_d.poison = 1'b0;
                end
            end else if (rl_take) begin
                s_d.val    = rl_data;
                s_d.poison = rl_poison;
            end
            if (rl_sel && rl_ok && !rl_take) begin
                s_d.scratch = rl_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign val_o     = s_q.val;
    assign poison_o  = s_q.poison;
    assign scratch_o = s_q.scratch;
endmodule

// File: rtl/cprf_top.sv
module cprf_top
    import cprf_pkg::*;
#(
    parameter int NREG = 16,
    parameter int DW   = 32,
    parameter int SEQW = 6,
    parameter int NRD  = 2,
    parameter int IW   = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic [DW-1:0]     wr_data,
    input  logic              wr_src_poison,
    input  logic              wr_miss,
    input  logic              rl_en,
    input  logic [IW-1:0]     rl_idx,
    input  logic [DW-1:0]     rl_data,
    input  logic [SEQW-1:0]   rl_seq,
    input  logic              rl_poison,
    input  logic              rally_start,
    input  logic              rally_done,
    input  logic              rally_abort,
    input  logic [NRD*IW-1:0] rd_idx,
    output logic [NRD*DW-1:0] rd_data,
    output logic [NRD-1:0]    rd_poison,
    input  logic [IW-1:0]     sc_idx,
    output logic [DW-1:0]     sc_data,
    output logic [1:0]        mode_o,
    output logic [SEQW-1:0]   seq_o,
    output logic              runahead_o
);
    cprf_mode_e      mode;
    logic            take_ckpt, restore, tail_we, tail_poison, rl_ok, rl_tag_en;
    logic [SEQW-1:0] tail_tag;

    logic [DW-1:0]   val_a     [NREG];
    logic            poison_a  [NREG];
    logic [DW-1:0]   scratch_a [NREG];

    cprf_ctrl #(.SEQW(SEQW)) ctrl_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_src_poison (wr_src_poison),
        .wr_miss       (wr_miss),
        .rally_start   (rally_start),
        .rally_done    (rally_done),
        .rally_abort   (rally_abort),
        .mode_o        (mode),
        .seq_o         (seq_o),
        .runahead_o    (runahead_o),
        .take_ckpt_o   (take_ckpt),
        .restore_o     (restore),
        .tail_we_o     (tail_we),
        .tail_poison_o (tail_poison),
        .tail_tag_o    (tail_tag),
        .rl_ok_o       (rl_ok),
        .rl_tag_en_o   (rl_tag_en)
    );

    assign mode_o = mode;

    for (genvar i = 0; i < NREG; i++) begin : g_slot
        logic tw_sel, rl_sel;
        assign tw_sel = tail_we && (wr_idx == IW'(i));
        assign rl_sel = rl_en && (rl_idx == IW'(i));
        cprf_slot #(.DW(DW), .SEQW(SEQW)) slot_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .take_ckpt (take_ckpt),
            .restore   (restore),
            .tw_sel    (tw_sel),
            .tw_data   (wr_data),
            .tw_poison (tail_poison),
            .tw_tag    (tail_tag),
            .rl_sel    (rl_sel),
            .rl_ok     (rl_ok),
            .rl_tag_en (rl_tag_en),
            .rl_data   (rl_data),
            .rl_seq    (rl_seq),
            .rl_poison (rl_poison),
            .val_o     (val_a[i]),
            .poison_o  (poison_a[i]),
            .scratch_o (scratch_a[i])
        );
    end

    for (genvar k = 0; k < NRD; k++) begin : g_rd
        assign rd_data[k*DW +: DW] = val_a[rd_idx[k*IW +: IW]];
        assign rd_poison[k]        = poison_a[rd_idx[k*IW +: IW]];
    end

    assign sc_data = scratch_a[sc_idx];
endmodule

// File: rtl/cprf_checker.sv
module cprf_checker #(
    parameter int SEQW = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic            wr_miss,
    input logic            rally_start,
    input logic            rally_done,
    input logic            rally_abort,
    input logic [1:0]      mode_o,
    input logic [SEQW-1:0] seq_o,
    input logic            runahead_o
);
    localparam logic [SEQW-1:0] SEQ_MAX = '1;

    p_ckpt_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd0 && wr_en && wr_miss) |=> (mode_o == 2'd1 && seq_o == SEQW'(1)));

    p_seq_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd1 && wr_en && seq_o != SEQ_MAX) |=> (seq_o == $past(seq_o) + SEQW'(1)));

    p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2 && rally_abort) |=> (mode_o == 2'd0 && seq_o == '0 && !runahead_o));

    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2 && rally_done && !rally_abort) |=> (mode_o == 2'd0 && seq_o == '0));

    p_saturate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != 2'd0 && wr_en && seq_o == SEQ_MAX && !rally_abort && !rally_done)
        |=> (runahead_o && seq_o == SEQ_MAX));

    p_normal_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd0 && !(wr_en && wr_miss)) |=> (mode_o == 2'd0));

    p_idle_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd0) |-> (seq_o == '0 && !runahead_o));
endmodule

bind cprf_top cprf_checker #(.SEQW(SEQW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_miss     (wr_miss),
    .rally_start (rally_start),
    .rally_done  (rally_done),
    .rally_abort (rally_abort),
    .mode_o      (mode_o),
    .seq_o       (seq_o),
    .runahead_o  (runahead_o)
);

// File: tb/cprf_top_tb_top.sv
`timescale 1ns/1ps
module cprf_top_tb_top;
    localparam int NREG = 16;
    localparam int DW   = 32;
    localparam int SEQW = 6;
    localparam int NRD  = 2;
    localparam int IW   = $clog2(NREG);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 0, wr_src_poison = 0, wr_miss = 0;
    logic [IW-1:0]     wr_idx = '0;
    logic [DW-1:0]     wr_data = '0;
    logic              rl_en = 0, rl_poison = 0;
    logic [IW-1:0]     rl_idx = '0;
    logic [DW-1:0]     rl_data = '0;
    logic [SEQW-1:0]   rl_seq = '0;
    logic              rally_start = 0, rally_done = 0, rally_abort = 0;
    logic [NRD*IW-1:0] rd_idx = '0;
    logic [NRD*DW-1:0] rd_data;
    logic [NRD-1:0]    rd_poison;
    logic [IW-1:0]     sc_idx = '0;
    logic [DW-1:0]     sc_data;
    logic [1:0]        mode_o;
    logic [SEQW-1:0]   seq_o;
    logic              runahead_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    cprf_top #(.NREG(NREG), .DW(DW), .SEQW(SEQW), .NRD(NRD)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .wr_src_poison(wr_src_poison), .wr_miss(wr_miss),
        .rl_en(rl_en), .rl_idx(rl_idx), .rl_data(rl_data),
        .rl_seq(rl_seq), .rl_poison(rl_poison),
        .rally_start(rally_start), .rally_done(rally_done), .rally_abort(rally_abort),
        .rd_idx(rd_idx), .rd_data(rd_data), .rd_poison(rd_poison),
        .sc_idx(sc_idx), .sc_data(sc_data),
        .mode_o(mode_o), .seq_o(seq_o), .runahead_o(runahead_o)
    );

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // one clock: strobes set by the caller are seen at this edge, then cleared
    task automatic cyc();
        @(posedge clk);
        #1;
        wr_en = 0; wr_src_poison = 0; wr_miss = 0;
        rl_en = 0; rl_poison = 0;
        rally_start = 0; rally_done = 0; rally_abort = 0;
    endtask

    task automatic twr(int idx, logic [DW-1:0] d, bit pois, bit miss);
        wr_en = 1; wr_idx = IW'(idx); wr_data = d; wr_src_poison = pois; wr_miss = miss;
    endtask

    task automatic rwr(int idx, logic [DW-1:0] d, int sq, bit pois);
        rl_en = 1; rl_idx = IW'(idx); rl_data = d; rl_seq = SEQW'(sq); rl_poison = pois;
    endtask

    task automatic rd_chk(string req, int port, int idx, logic [DW-1:0] ev, bit ep);
        rd_idx[port*IW +: IW] = IW'(idx);
        #0.3;
        chk(req, $sformatf("r%0d value", idx), 64'(rd_data[port*DW +: DW]), 64'(ev));
        chk(req, $sformatf("r%0d poison", idx), 64'(rd_poison[port]), 64'(ep));
    endtask

    task automatic sc_chk(string req, int idx, logic [DW-1:0] ev);
        sc_idx = IW'(idx);
        #0.3;
        chk(req, $sformatf("scratch r%0d", idx), 64'(sc_data), 64'(ev));
    endtask

    task automatic state_chk(string req, int em, int es, bit er);
        chk(req, "mode", 64'(mode_o), 64'(em));
        chk(req, "seq", 64'(seq_o), 64'(es));
        chk(req, "fallback", 64'(runahead_o), 64'(er));
    endtask

    task automatic t_reset();
        state_chk("R1", 0, 0, 0);
        rd_chk("R1", 0, 3, '0, 0);
        rd_chk("R1", 1, 15, '0, 0);
    endtask

    task automatic t_normal();
        twr(1, 32'h11, 0, 0); cyc();
        twr(2, 32'h22, 1, 0); cyc();   // poisoned-source flag has no meaning in normal mode
        twr(3, 32'h33, 0, 0); cyc();
        rd_chk("R12", 0, 1, 32'h11, 0);
        rd_chk("R12", 1, 2, 32'h22, 0);
        state_chk("R12", 0, 0, 0);
    endtask

    task automatic t_ignored();
        rally_start = 1; rally_done = 1; rally_abort = 1;
        rwr(1, 32'hBAD, 0, 1);
        cyc();
        state_chk("R11", 0, 0, 0);
        rd_chk("R11", 0, 1, 32'h11, 0);
        sc_chk("R11", 1, '0);
    endtask

    task automatic t_advance_rally();
        twr(2, 32'hDEAD, 0, 1); cyc();          // miss: ckpt, r2 tag 1
        state_chk("R2", 1, 1, 0);
        rd_chk("R2", 0, 2, 32'h22, 1);
        twr(4, 32'h44, 1, 0); cyc();            // r4 tag 2, poisoned
        rd_chk("R3", 0, 4, '0, 1);
        chk("R5", "seq", 64'(seq_o), 64'd2);
        twr(3, 32'h3333, 0, 0); cyc();          // r3 tag 3
        twr(2, 32'h2222, 0, 0); cyc();          // r2 tag 4, unpoisoned
        rd_chk("R4", 0, 2, 32'h2222, 0);
        rd_chk("R4", 1, 3, 32'h3333, 0);
        chk("R5", "seq", 64'(seq_o), 64'd4);
        // rally writes ignored while still in advance mode
        rwr(4, 32'hCAFE, 2, 0); cyc();
        rd_chk("R11", 0, 4, '0, 1);
        sc_chk("R11", 4, '0);
        rally_start = 1; cyc();
        state_chk("R6", 2, 4, 0);
        rwr(2, 32'hAAAA, 1, 0); cyc();          // stale tag
        rd_chk("R6", 0, 2, 32'h2222, 0);
        sc_chk("R6", 2, 32'hAAAA);
        rwr(4, 32'h4444, 2, 0); cyc();          // matching tag
        rd_chk("R6", 0, 4, 32'h4444, 0);
        // collision: tail and rally both target r3, rally tag matches
        twr(3, 32'h5555, 0, 0); rwr(3, 32'h7777, 3, 0); cyc();
        rd_chk("R7", 0, 3, 32'h5555, 0);
        sc_chk("R7", 3, 32'h7777);
        chk("R7", "seq", 64'(seq_o), 64'd5);
        // abort together with a tail write: write discarded
        rally_abort = 1; twr(1, 32'h9999, 0, 0); cyc();
        state_chk("R8", 0, 0, 0);
        rd_chk("R8", 0, 1, 32'h11, 0);
        rd_chk("R8", 1, 2, 32'h22, 0);
        rd_chk("R8", 0, 3, 32'h33, 0);
        rd_chk("R8", 1, 4, '0, 0);
    endtask

    task automatic t_release();
        twr(5, 32'h1, 0, 1); cyc();             // r5 tag 1
        twr(6, 32'h66, 0, 0); cyc();            // r6 tag 2
        rally_start = 1; cyc();
        rwr(5, 32'h55, 1, 0); cyc();
        rally_done = 1; cyc();
        state_chk("R9", 0, 0, 0);
        rd_chk("R9", 0, 5, 32'h55, 0);
        rd_chk("R9", 1, 6, 32'h66, 0);
    endtask

    task automatic t_saturate();
        twr(7, 32'h0, 0, 1); cyc();             // seq 1
        for (int i = 0; i < 62; i++) begin
            twr(8, 32'(i), 0, 0); cyc();
        end
        state_chk("R10", 1, 63, 0);
        twr(8, 32'hF00, 0, 0); cyc();
        state_chk("R10", 1, 63, 1);
        rd_chk("R10", 0, 8, 32'hF00, 0);
        rally_start = 1; cyc();
        rwr(7, 32'h77, 1, 0); cyc();            // tag would match, but fallback blocks it
        rd_chk("R10", 0, 7, '0, 1);
        sc_chk("R10", 7, 32'h77);
        chk("R10", "fallback held", 64'(runahead_o), 64'd1);
        rally_abort = 1; cyc();
        state_chk("R8", 0, 0, 0);
        rd_chk("R8", 0, 7, '0, 0);
        rd_chk("R8", 1, 8, '0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_normal();
        t_ignored();
        t_advance_rally();
        t_release();
        t_saturate();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule